// File: doc/BRIEF.md
# Variable-Length VLIW Packet Aligner

This block sits between an instruction fetch buffer and the issue stage of a wide-issue core. Fetch delivers a dense stream of 32-bit instruction words, four at a time, as one 128-bit window under a valid/ready handshake. Packets are stored back to back in memory with no filler words. Each packet holds one to four instructions, so a packet can start anywhere inside a window and can run across into the next window.

The first word of every packet carries a two-bit length header in bits [31:30]. The aligner reads that header, waits until every word of the packet is buffered, and then presents the packet in slot order on four output slots. A slot's position selects the execution lane, so the first instruction always lands in slot 0. Words that are left after a packet stay in an internal holding buffer of eight words and start the next packet. A flush input, used on a branch redirect, discards everything held and restarts header parsing at word 0 of the next accepted window.

A small controller has three states. ST_EMPTY means the buffer holds no words. ST_WAIT means it holds the start of a packet but not all of its words. ST_ISSUE means the packet at the head is complete and is popped in that cycle. The transitions are:
- EMPTY to WAIT, or EMPTY to ISSUE, when a window arrives.
- WAIT to ISSUE when the missing words arrive.
- ISSUE to ISSUE, WAIT or EMPTY, depending on what remains after the pop.
- Any state to EMPTY on flush.

Top module: `vpa_packet_aligner`

## Requirements
- R1: After reset, out_valid is 0, out_mask is 0, out_count is 0, and in_ready is 1 while flush is low.
- R2: Bits [31:30] of a packet's first word hold the instruction count minus one (00 means 1, 11 means 4). When out_valid is 1, out_count equals that count and out_mask has bit i set exactly for i < out_count.
- R3: Word j of the input window is in_window[32*j+31:32*j], and a lower j comes earlier in program order. Instruction k of a packet appears on out_slots[32*k+31:32*k].
- R4: Packets are contiguous. The word after a packet's last word is the next packet's header, including when a packet crosses a window boundary, and no word is lost or repeated.
- R5: Output slots at or above out_count are 0. When out_valid is 0, out_slots, out_mask and out_count are all 0.
- R6: No packet is presented until all of its words are held. With only part of a packet buffered, out_valid stays 0.
- R7: in_ready is 1 exactly when flush is 0 and at most 4 words are held. A window is taken only on a cycle where in_valid and in_ready are both 1.
- R8: While flush is 1, in_ready is 0. On the cycle after flush, out_valid is 0. Every held word, including a packet being popped in the flush cycle, is discarded, and the next accepted window is parsed from its word 0.
- R9: A packet that is complete in the buffer after clock edge N is shown for exactly one cycle, starting at edge N+1. If four-instruction packets arrive on every cycle, one packet leaves on every cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard held words and restart alignment |
| in_valid | input | 1 | Fetch window present |
| in_window | input | 128 | Four instruction words, word 0 in the low bits |
| in_ready | output | 1 | Aligner can take a full window |
| out_valid | output | 1 | Aligned packet present this cycle |
| out_slots | output | 128 | Four instruction slots, slot 0 in the low bits |
| out_mask | output | 4 | Per-slot valid bits |
| out_count | output | 3 | Number of instructions in the packet (1 to 4) |

## Verification
The checker watches properties that can be seen from the ports on every cycle:
- the header of slot 0 agrees with out_count;
- the mask has the shape set by the count;
- unused slots and the idle outputs are zero;
- flush lowers ready and stops output on the next cycle;
- the count of accepted words that have not yet been emitted stays within the buffer plus one output register.

Only the bench's scenarios can show the rest:
- that the correct words come out in order across window boundaries;
- that an incomplete packet is held back;
- that ready drops when seven words are buffered;
- that words from before a flush never appear;
- that the one-cycle latency and the full rate of one packet per cycle are met.

// File: rtl/vpa_pkg.sv
`timescale 1ns/1ps
package vpa_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2
    } align_state_e;
endpackage

// File: rtl/vpa_hdr_decode.sv
`timescale 1ns/1ps
module vpa_hdr_decode #(
    parameter int MAX_SLOTS = 4,
    localparam int HDR_W = $clog2(MAX_SLOTS),
    localparam int LEN_W = $clog2(MAX_SLOTS + 1)
) (
    input  logic [HDR_W-1:0] hdr_field,
    output logic [LEN_W-1:0] pkt_len
);
    // Header field stores count minus one.
    assign pkt_len = LEN_W'(hdr_field) + LEN_W'(1);
endmodule

// File: rtl/vpa_word_buf.sv
`timescale 1ns/1ps
module vpa_word_buf #(
    parameter int WORD_W      = 32,
    parameter int FETCH_WORDS = 4,
    parameter int MAX_SLOTS   = 4,
    parameter int BUF_WORDS   = 8,
    localparam int CNT_W = $clog2(BUF_WORDS + 1),
    localparam int HDR_W = $clog2(MAX_SLOTS),
    localparam int BUF_W = BUF_WORDS * WORD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          push,
    input  logic [FETCH_WORDS*WORD_W-1:0] push_data,
    input  logic [CNT_W-1:0]              pop_n,
    output logic [MAX_SLOTS*WORD_W-1:0]   front_q,
    output logic [CNT_W-1:0]              cnt_q,
    output logic [CNT_W-1:0]              cnt_nxt,
    output logic [HDR_W-1:0]              hdr_nxt
);
    logic [BUF_W-1:0] flat_q;
    logic [BUF_W-1:0] flat_nxt;
    logic [CNT_W-1:0] remain;

    always_comb begin
        remain   = cnt_q - pop_n;
        // Words above the count are always zero, so the shifted-in zeros
        // leave room for the new window to be OR-ed in after the survivors.
        flat_nxt = flat_q >> (pop_n * WORD_W);
        if (push) begin
            flat_nxt = flat_nxt | (BUF_W'(push_data) << (remain * WORD_W));
        end
        cnt_nxt = remain + (push ? CNT_W'(FETCH_WORDS) : '0);
        if (clr) begin
            flat_nxt = '0;
            cnt_nxt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flat_q <= '0;
            cnt_q  <= '0;
        end else begin
            flat_q <= flat_nxt;
            cnt_q  <= cnt_nxt;
        end
    end

    assign front_q = flat_q[MAX_SLOTS*WORD_W-1:0];
    assign hdr_nxt = flat_nxt[WORD_W-1 -: HDR_W];
endmodule

// File: rtl/vpa_slot_drive.sv
`timescale 1ns/1ps
module vpa_slot_drive #(
    parameter int WORD_W    = 32,
    parameter int MAX_SLOTS = 4,
    localparam int LEN_W = $clog2(MAX_SLOTS + 1)
) (
    input  logic [MAX_SLOTS*WORD_W-1:0] front,
    input  logic [LEN_W-1:0]            pkt_len,
    output logic [MAX_SLOTS*WORD_W-1:0] slots,
    output logic [MAX_SLOTS-1:0]        mask
);
    for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
        assign mask[s] = pkt_len > LEN_W'(s);
        assign slots[s*WORD_W +: WORD_W] = mask[s] ? front[s*WORD_W +: WORD_W] : '0;
    end
endmodule

// File: rtl/vpa_packet_aligner.sv
`timescale 1ns/1ps
module vpa_packet_aligner #(
    parameter int WORD_W      = 32,
    parameter int FETCH_WORDS = 4,
    parameter int MAX_SLOTS   = 4,
    parameter int BUF_WORDS   = 8,
    localparam int CNT_W = $clog2(BUF_WORDS + 1),
    localparam int HDR_W = $clog2(MAX_SLOTS),
    localparam int LEN_W = $clog2(MAX_SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          in_valid,
    input  logic [FETCH_WORDS*WORD_W-1:0] in_window,
    output logic                          in_ready,
    output logic                          out_valid,
    output logic [MAX_SLOTS*WORD_W-1:0]   out_slots,
    output logic [MAX_SLOTS-1:0]          out_mask,
    output logic [LEN_W-1:0]              out_count
);
    import vpa_pkg::*;

    align_state_e state_q, state_nxt;

    logic                        accept;
    logic                        issue;
    logic [CNT_W-1:0]            pop_n;
    logic [MAX_SLOTS*WORD_W-1:0] front;
    logic [CNT_W-1:0]            cnt_q, cnt_nxt;
    logic [HDR_W-1:0]            hdr_nxt;
    logic [LEN_W-1:0]            head_len, nxt_len;
    logic [MAX_SLOTS*WORD_W-1:0] drv_slots;
    logic [MAX_SLOTS-1:0]        drv_mask;

    assign in_ready = !flush && (cnt_q <= CNT_W'(BUF_WORDS - FETCH_WORDS));
    assign accept   = in_valid && in_ready;
    assign pop_n    = issue ? CNT_W'(head_len) : '0;

    vpa_word_buf #(
        .WORD_W(WORD_W), .FETCH_WORDS(FETCH_WORDS),
        .MAX_SLOTS(MAX_SLOTS), .BUF_WORDS(BUF_WORDS)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(flush), .push(accept),
        .push_data(in_window), .pop_n(pop_n), .front_q(front),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .hdr_nxt(hdr_nxt)
    );

    vpa_hdr_decode #(.MAX_SLOTS(MAX_SLOTS)) u_hdr_now (
        .hdr_field(front[WORD_W-1 -: HDR_W]), .pkt_len(head_len)
    );

    vpa_hdr_decode #(.MAX_SLOTS(MAX_SLOTS)) u_hdr_nxt (
        .hdr_field(hdr_nxt), .pkt_len(nxt_len)
    );

    vpa_slot_drive #(.WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS)) u_drive (
        .front(front), .pkt_len(head_len), .slots(drv_slots), .mask(drv_mask)
    );

    // Next state from what the buffer will hold after this edge.
    always_comb begin
        if (flush || cnt_nxt == '0) begin
            state_nxt = ST_EMPTY;
        end else if (cnt_nxt >= CNT_W'(nxt_len)) begin
            state_nxt = ST_ISSUE;
        end else begin
            state_nxt = ST_WAIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: issue = 1'b0;
            ST_WAIT:  issue = 1'b0;
            ST_ISSUE: issue = 1'b1;
            default:  issue = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_slots <= '0;
            out_mask  <= '0;
            out_count <= '0;
        end else if (flush || !issue) begin
            out_valid <= 1'b0;
            out_slots <= '0;
            out_mask  <= '0;
            out_count <= '0;
        end else begin
            out_valid <= 1'b1;
            out_slots <= drv_slots;
            out_mask  <= drv_mask;
            out_count <= head_len;
        end
    end
endmodule

// File: rtl/vpa_packet_aligner_chk.sv
`timescale 1ns/1ps
module vpa_packet_aligner_chk #(
    parameter int WORD_W      = 32,
    parameter int FETCH_WORDS = 4,
    parameter int MAX_SLOTS   = 4,
    parameter int BUF_WORDS   = 8,
    localparam int HDR_W = $clog2(MAX_SLOTS),
    localparam int LEN_W = $clog2(MAX_SLOTS + 1),
    localparam int OCC_W = $clog2(BUF_WORDS + MAX_SLOTS + FETCH_WORDS + 1) + 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          flush,
    input logic                          in_valid,
    input logic [FETCH_WORDS*WORD_W-1:0] in_window,
    input logic                          in_ready,
    input logic                          out_valid,
    input logic [MAX_SLOTS*WORD_W-1:0]   out_slots,
    input logic [MAX_SLOTS-1:0]          out_mask,
    input logic [LEN_W-1:0]              out_count
);
    logic [MAX_SLOTS-1:0]        mask_ref;
    logic [MAX_SLOTS*WORD_W-1:0] keep;
    logic [OCC_W-1:0]            occ_q;
    logic [FETCH_WORDS*WORD_W-1:0] win_seen;

    assign win_seen = in_window;

    always_comb begin
        for (int s = 0; s < MAX_SLOTS; s++) begin
            mask_ref[s] = LEN_W'(s) < out_count;
            keep[s*WORD_W +: WORD_W] = {WORD_W{out_mask[s]}};
        end
    end

    // Words taken in but not yet shown on the outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (flush) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + ((in_valid && in_ready) ? OCC_W'(FETCH_WORDS) : '0)
                           - (out_valid ? OCC_W'(out_count) : '0);
        end
    end

    AST_HDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (LEN_W'(out_slots[WORD_W-1 -: HDR_W]) + LEN_W'(1)) == out_count); // R2
    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask == mask_ref && out_count != '0)); // R2
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_slots & ~keep) == '0); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_mask == '0 && out_count == '0 && out_slots == '0)); // R5
    AST_FLUSH_NOREADY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready); // R8
    AST_FLUSH_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(BUF_WORDS + MAX_SLOTS)); // R7
    AST_WIN_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> !$isunknown(win_seen)); // R7
endmodule

bind vpa_packet_aligner vpa_packet_aligner_chk #(
    .WORD_W(WORD_W), .FETCH_WORDS(FETCH_WORDS),
    .MAX_SLOTS(MAX_SLOTS), .BUF_WORDS(BUF_WORDS)
) u_chk (.*);

// File: tb/tb_vpa_packet_aligner.sv
`timescale 1ns/1ps
module tb_vpa_packet_aligner;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;
    localparam int N_TBL      = 14;
    localparam int PKT_LENS [N_TBL] = '{1, 4, 2, 3, 3, 1, 2, 4, 4, 1, 1, 1, 2, 3};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_window = '0;
    logic         in_ready;
    logic         out_valid;
    logic [127:0] out_slots;
    logic [3:0]   out_mask;
    logic [2:0]   out_count;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int pkt_id = 0;

    logic [31:0]  strm [64];
    int           strm_n = 0;
    logic [127:0] exp_pkt [64];
    int           exp_len [64];
    int           exp_n = 0;
    int           got_n = 0;
    int           got_cyc [64];

    vpa_packet_aligner dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_window(in_window), .in_ready(in_ready), .out_valid(out_valid),
        .out_slots(out_slots), .out_mask(out_mask), .out_count(out_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [127:0] got,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got=%0d expected<%0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] mk_word(input int len, input int pid, input int s);
        if (s == 0) return {2'(len - 1), 6'h15, 8'(pid), 8'(s), 8'hC3};
        return {2'(pid + s), 6'h2A, 8'(pid), 8'(s), 8'h5A};
    endfunction

    task automatic add_pkt(input int len);
        logic [127:0] p;
        p = '0;
        for (int s = 0; s < len; s++) begin
            strm[strm_n] = mk_word(len, pkt_id, s);
            p[s*32 +: 32] = strm[strm_n];
            strm_n++;
        end
        exp_pkt[exp_n] = p;
        exp_len[exp_n] = len;
        exp_n++;
        pkt_id++;
    endtask

    // Monitor: compares every presented packet with the expected list in order.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (got_n >= exp_n) begin
                chk(1'b0, "R4/R8 unexpected packet", out_slots, '0);
            end else begin
                logic [3:0] m;
                m = 4'((1 << exp_len[got_n]) - 1);
                chk(out_count == 3'(exp_len[got_n]), "R2 count", 128'(out_count),
                    128'(exp_len[got_n]));
                chk(out_mask == m, "R2 mask", 128'(out_mask), 128'(m));
                chk(out_slots == exp_pkt[got_n], "R3/R4/R5 slots", out_slots,
                    exp_pkt[got_n]);
            end
            got_cyc[got_n] = cyc;
            got_n++;
        end
    end

    task automatic send(input logic [127:0] w);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1;
        in_window = w;
        forever begin
            #1 ok = in_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
        #1 in_valid = 1'b0;
    endtask

    task automatic send_stream();
        for (int w = 0; w < strm_n; w += 4) begin
            logic [127:0] win;
            win = '0;
            for (int j = 0; j < 4; j++) win[j*32 +: 32] = strm[w + j];
            send(win);
        end
    endtask

    task automatic fresh();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        strm_n = 0; exp_n = 0; got_n = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'(0));
        chk(out_mask == 4'd0, "R1 out_mask", 128'(out_mask), 128'(0));
        chk(out_count == 3'd0, "R1 out_count", 128'(out_count), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready", 128'(in_ready), 128'(1));

        // Table walk: R2 R3 R4 R5 with straddling packets
        for (int i = 0; i < N_TBL; i++) add_pkt(PKT_LENS[i]);
        send_stream();
        repeat (8) @(negedge clk);
        chk(got_n == N_TBL, "R4 packet total", 128'(got_n), 128'(N_TBL));

        // R6: incomplete four-word packet held back
        fresh();
        add_pkt(1); add_pkt(1); add_pkt(4); add_pkt(2);
        begin
            logic [127:0] win;
            for (int j = 0; j < 4; j++) win[j*32 +: 32] = strm[j];
            send(win);
            repeat (5) @(negedge clk);
            chk(got_n == 2, "R6 partial held count", 128'(got_n), 128'(2));
            chk(out_valid == 1'b0, "R6 out_valid low", 128'(out_valid), 128'(0));
            for (int j = 0; j < 4; j++) win[j*32 +: 32] = strm[4 + j];
            send(win);
        end
        repeat (5) @(negedge clk);
        chk(got_n == 4, "R6 completed after rest", 128'(got_n), 128'(4));

        // R7: ready drops with seven words held
        fresh();
        for (int i = 0; i < 8; i++) add_pkt(1);
        send_stream();
        @(negedge clk); #1;
        chk(in_ready == 1'b0, "R7 ready low when full", 128'(in_ready), 128'(0));
        repeat (10) @(negedge clk);
        chk(in_ready == 1'b1, "R7 ready back when drained", 128'(in_ready), 128'(1));
        chk(got_n == 8, "R7 no word lost", 128'(got_n), 128'(8));

        // R8: flush discards held words and a popping packet
        fresh();
        for (int i = 0; i < 4; i++) add_pkt(1);
        exp_n = 0;
        send_stream();
        @(negedge clk); flush = 1'b1;
        #1 chk(in_ready == 1'b0, "R8 ready low in flush", 128'(in_ready), 128'(0));
        @(negedge clk); flush = 1'b0;
        chk(out_valid == 1'b0, "R8 no output after flush", 128'(out_valid), 128'(0));
        repeat (4) @(negedge clk);
        chk(got_n == 0, "R8 flushed words dropped", 128'(got_n), 128'(0));
        strm_n = 0;
        add_pkt(2); add_pkt(2);
        send_stream();
        repeat (5) @(negedge clk);
        chk(got_n == 2, "R8 restart at word 0", 128'(got_n), 128'(2));

        // R9 latency: complete after edge N, shown from N+1 for one cycle
        fresh();
        add_pkt(4);
        send_stream();
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 not before N+1", 128'(out_valid), 128'(0));
        @(negedge clk);
        chk(out_valid == 1'b1, "R9 shown at N+1", 128'(out_valid), 128'(1));
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 one cycle only", 128'(out_valid), 128'(0));

        // R9 throughput: four-word packets every cycle
        fresh();
        for (int i = 0; i < 4; i++) add_pkt(4);
        send_stream();
        repeat (6) @(negedge clk);
        chk(got_n == 4, "R9 throughput count", 128'(got_n), 128'(4));
        chk(got_cyc[3] - got_cyc[0] == 3, "R9 no bubble", 128'(got_cyc[3] - got_cyc[0]),
            128'(3));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule